// File: doc/BRIEF.md
# Dynamic Bus Sizing Sequencer

This block sits between a processor core's memory port and a 16-bit external data bus. The bus has two active-low byte-lane enables. The core asks for a byte or a 16-bit word at an address. The sequencer turns that request into one or two external transactions. Each transaction stays open until the bus side signals completion with `bus_ack`. In the same cycle as `bus_ack`, the bus side reports through `bus_byte_n` whether the addressed memory is only one byte wide.

In a word, the even byte (address bit 0 = 0) belongs on the low lane, bits 7:0, and the odd byte belongs on the high lane, bits 15:8. Byte-wide memories are wired to the low lane only. When a word access meets a byte-wide memory, the block handles it without the core's involvement:
- The first transaction moves the even byte.
- The block then issues a second transaction with address bit 0 set. This transaction moves the odd byte, also on the low lane.

On reads, the first byte is held in a register. The combined word goes to the core only when the second transaction ends.

The control is one state machine with four states:
- `ST_IDLE`: waiting for a request.
- `ST_FIRST`: the first external transaction is in progress.
- `ST_SECOND`: the follow-up transaction of a split word is in progress.
- `ST_RESP`: a one-cycle completion to the core.

It has five transitions:
- IDLE→FIRST when a request is accepted.
- FIRST→SECOND on an ack that reports a byte-wide memory during a word request.
- FIRST→RESP on any other ack.
- SECOND→RESP on the second ack.
- RESP→IDLE unconditionally.

Top module: `bus_size_seq`

## Requirements
- R1: After reset the block shows `req_ready`=1, `bus_cyc`=0, `core_done`=0, and both lane enables high.
- R2: A request is accepted only when `req_valid` and `req_ready` are both high. `bus_cyc` rises on the next clock. While a transaction is in progress, `req_ready` is 0 and any `req_valid` is ignored: the bus address and direction stay unchanged.
- R3: The first transaction of a word request asserts both enables low and drives address bit 0 as 0, even when the core gave an odd word address. On a write it drives core data bits 15:8 on bus bits 15:8 and core bits 7:0 on bus bits 7:0.
- R4: A byte request issues exactly one transaction. Only the addressed lane's enable is low: address bit 0 = 0 selects `bus_len_n`, and address bit 0 = 1 selects `bus_hen_n`. On a write, the byte from core bits 7:0 is driven on both lanes.
- R5: `bus_byte_n` (active low = byte-wide memory) is sampled only in the cycle `bus_ack` is high. Its value in wait cycles has no effect. A word request whose first ack sees it low starts a second transaction.
- R6: The second transaction keeps the upper address bits and sets address bit 0 to 1. It has only `bus_len_n` low. On a write, it drives core data bits 15:8 on both lanes. `bus_byte_n` at its ack is ignored.
- R7: A word read completed in one transaction returns `bus_rdata` as sampled at the ack.
- R8: A split word read returns {low lane of the second ack, low lane of the first ack}.
- R9: A byte read returns zero in bits 15:8. Bits 7:0 come from the low lane if `bus_byte_n` was low at the ack, and otherwise from the addressed lane.
- R10: `core_done` is a one-cycle pulse in the cycle after the final ack, with `core_rdata` valid. `req_ready` returns on the following cycle.
- R11: During a transaction, address, enables and direction hold until the ack. Outside a transaction both enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Core request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_addr | input | AW | Core byte address |
| req_wdata | input | 2*LW | Write data (byte requests use bits 7:0) |
| req_ready | output | 1 | Block can accept a request |
| core_done | output | 1 | One-cycle completion pulse |
| core_rdata | output | 2*LW | Read result, valid with core_done |
| bus_cyc | output | 1 | External transaction in progress |
| bus_we | output | 1 | Transaction direction is write |
| bus_addr | output | AW | External address |
| bus_hen_n | output | 1 | High-lane (15:8) enable, active low |
| bus_len_n | output | 1 | Low-lane (7:0) enable, active low |
| bus_wdata | output | 2*LW | Write data on the lanes |
| bus_rdata | input | 2*LW | Read data from the lanes |
| bus_ack | input | 1 | Transaction completes this cycle |
| bus_byte_n | input | 1 | Byte-wide memory, active low, sampled with ack |

## Verification
The bench holds `bus_byte_n` low during wait states and releases it only at the ack. A design that samples the width early would split a word meant to go across the full bus. A split read returns distinct bytes in each transaction, so swapped halves or a hold register that is never loaded show up as a wrong word. A design that forgets to move the odd byte to the low lane, or leaves address bit 0 at 0, fails on the second transaction's address, enables and write data. Odd-address byte requests, with and without the byte-wide flag, catch wrong lane selection. An odd word address and a request raised mid-transaction catch address alignment errors and a design that takes requests while busy.

// File: rtl/bsz_pkg.sv
package bsz_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FIRST  = 2'd1,
        ST_SECOND = 2'd2,
        ST_RESP   = 2'd3
    } bsz_state_t;

    typedef struct packed {
        logic write;
        logic word;
        logic a0;
    } bsz_kind_t;

endpackage

// File: rtl/bsz_fsm.sv
module bsz_fsm
    import bsz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       is_word,
    input  logic       bus_ack,
    input  logic       bus_byte_n,
    output bsz_state_t state,
    output logic       req_ready,
    output logic       bus_cyc,
    output logic       in_second,
    output logic       ack_first,
    output logic       ack_second,
    output logic       core_done
);

    bsz_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_FIRST;
            ST_FIRST:  if (bus_ack)   state_nx = (is_word && !bus_byte_n) ? ST_SECOND : ST_RESP;
            ST_SECOND: if (bus_ack)   state_nx = ST_RESP;
            ST_RESP:                  state_nx = ST_IDLE;
            default:                  state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready  = (state == ST_IDLE);
        bus_cyc    = (state == ST_FIRST) || (state == ST_SECOND);
        in_second  = (state == ST_SECOND);
        ack_first  = (state == ST_FIRST) && bus_ack;
        ack_second = (state == ST_SECOND) && bus_ack;
        core_done  = (state == ST_RESP);
    end

    // R6
    second_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SECOND |-> ($past(state) == ST_FIRST || $past(state) == ST_SECOND));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> (!core_done && req_ready));

endmodule

// File: rtl/bsz_lane_steer.sv
module bsz_lane_steer #(
    parameter int LW = 8
) (
    input  logic            bus_cyc,
    input  logic            in_second,
    input  logic            is_word,
    input  logic            a0,
    input  logic [2*LW-1:0] wdata,
    output logic            hen_n,
    output logic            len_n,
    output logic            a0_out,
    output logic [2*LW-1:0] wdata_out
);

    localparam int DW = 2 * LW;

    logic [LW-1:0] lo_byte;
    logic [LW-1:0] hi_byte;

    assign lo_byte = wdata[LW-1:0];
    assign hi_byte = wdata[DW-1:LW];

    always_comb begin
        hen_n     = 1'b1;
        len_n     = 1'b1;
        a0_out    = a0;
        wdata_out = {lo_byte, lo_byte};
        if (in_second) begin
            len_n     = !bus_cyc;
            a0_out    = 1'b1;
            wdata_out = {hi_byte, hi_byte};
        end else if (is_word) begin
            hen_n     = !bus_cyc;
            len_n     = !bus_cyc;
            a0_out    = 1'b0;
            wdata_out = wdata;
        end else begin
            hen_n = !(bus_cyc && a0);
            len_n = !(bus_cyc && !a0);
        end
    end

endmodule

// File: rtl/bsz_read_merge.sv
module bsz_read_merge #(
    parameter int LW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ack_first,
    input  logic            ack_second,
    input  logic            is_word,
    input  logic            a0,
    input  logic            bus_byte_n,
    input  logic [2*LW-1:0] bus_rdata,
    output logic [2*LW-1:0] rdata
);

    localparam int DW = 2 * LW;

    logic [LW-1:0] hold_q;
    logic [LW-1:0] pick;

    assign pick = (bus_byte_n && a0) ? bus_rdata[DW-1:LW] : bus_rdata[LW-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= '0;
            rdata  <= '0;
        end else if (ack_first) begin
            if (is_word && !bus_byte_n) hold_q <= bus_rdata[LW-1:0];
            else if (is_word)           rdata  <= bus_rdata;
            else                        rdata  <= {{LW{1'b0}}, pick};
        end else if (ack_second) begin
            rdata <= {bus_rdata[LW-1:0], hold_q};
        end
    end

    // R8
    merge_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack_second |=> rdata[LW-1:0] == $past(hold_q));

endmodule

// File: rtl/bus_size_seq.sv
module bus_size_seq
    import bsz_pkg::*;
#(
    parameter int AW = 24,
    parameter int LW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [AW-1:0]     req_addr,
    input  logic [2*LW-1:0]   req_wdata,
    output logic              req_ready,
    output logic              core_done,
    output logic [2*LW-1:0]   core_rdata,
    output logic              bus_cyc,
    output logic              bus_we,
    output logic [AW-1:0]     bus_addr,
    output logic              bus_hen_n,
    output logic              bus_len_n,
    output logic [2*LW-1:0]   bus_wdata,
    input  logic [2*LW-1:0]   bus_rdata,
    input  logic              bus_ack,
    input  logic              bus_byte_n
);

    localparam int DW = 2 * LW;

    bsz_state_t      state;
    bsz_kind_t       kind_q;
    logic [AW-1:0]   addr_q;
    logic [DW-1:0]   wdata_q;
    logic            in_second;
    logic            ack_first;
    logic            ack_second;
    logic            a0_out;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (req_ready && req_valid) begin
            kind_q  <= '{write: req_write, word: req_word, a0: req_word ? 1'b0 : req_addr[0]};
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
        end
    end

    bsz_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .is_word    (kind_q.word),
        .bus_ack    (bus_ack),
        .bus_byte_n (bus_byte_n),
        .state      (state),
        .req_ready  (req_ready),
        .bus_cyc    (bus_cyc),
        .in_second  (in_second),
        .ack_first  (ack_first),
        .ack_second (ack_second),
        .core_done  (core_done)
    );

    bsz_lane_steer #(.LW(LW)) u_steer (
        .bus_cyc   (bus_cyc),
        .in_second (in_second),
        .is_word   (kind_q.word),
        .a0        (kind_q.a0),
        .wdata     (wdata_q),
        .hen_n     (bus_hen_n),
        .len_n     (bus_len_n),
        .a0_out    (a0_out),
        .wdata_out (bus_wdata)
    );

    bsz_read_merge #(.LW(LW)) u_merge (
        .clk        (clk),
        .rst_n      (rst_n),
        .ack_first  (ack_first),
        .ack_second (ack_second),
        .is_word    (kind_q.word),
        .a0         (kind_q.a0),
        .bus_byte_n (bus_byte_n),
        .bus_rdata  (bus_rdata),
        .rdata      (core_rdata)
    );

    assign bus_addr = {addr_q[AW-1:1], a0_out};
    assign bus_we   = bus_cyc && kind_q.write;

    // R11
    idle_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_cyc |-> (bus_hen_n && bus_len_n));

    // R11
    hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !bus_ack) |=> ($stable(bus_addr) && $stable(bus_hen_n) && $stable(bus_len_n) && $stable(bus_we)));

    // R4
    byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !kind_q.word) |-> (bus_hen_n != bus_len_n));

    // R4
    byte_single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cyc && !kind_q.word && bus_ack) |=> core_done);

    // R6
    second_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SECOND) |-> (bus_addr[0] && !bus_len_n && bus_hen_n));

    // R3
    word_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FIRST && kind_q.word) |-> (!bus_hen_n && !bus_len_n && !bus_addr[0]));

endmodule

// File: tb/test_bus_size_seq.sv
`timescale 1ns/1ps
module test_bus_size_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_word = 1'b0;
    logic [23:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        req_ready;
    logic        core_done;
    logic [15:0] core_rdata;
    logic        bus_cyc;
    logic        bus_we;
    logic [23:0] bus_addr;
    logic        bus_hen_n;
    logic        bus_len_n;
    logic [15:0] bus_wdata;
    logic [15:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        bus_byte_n = 1'b1;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    bus_size_seq i_bus_size_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_word(req_word), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_ready(req_ready), .core_done(core_done), .core_rdata(core_rdata),
        .bus_cyc(bus_cyc), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_hen_n(bus_hen_n), .bus_len_n(bus_len_n), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .bus_byte_n(bus_byte_n)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Request presented at a negedge; on return (next negedge) the transaction is open.
    task automatic issue(input logic wr, input logic wd, input logic [23:0] a, input logic [15:0] d);
        req_valid = 1'b1; req_write = wr; req_word = wd; req_addr = a; req_wdata = d;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Snapshot bus outputs, wait, then ack with given data and width flag.
    task automatic xfer(input int waits, input logic [15:0] rd, input logic bn,
                        output logic [23:0] a, output logic [1:0] en,
                        output logic [15:0] wd, output logic we);
        a = bus_addr; en = {bus_hen_n, bus_len_n}; wd = bus_wdata; we = bus_we;
        check("R2 bus_cyc open", {31'd0, bus_cyc}, 32'd1);
        for (int i = 0; i < waits; i++) begin
            bus_byte_n = ~bn;
            @(posedge clk); @(negedge clk);
        end
        if (waits > 0) check("R11 address held", {8'd0, bus_addr}, {8'd0, a});
        bus_ack = 1'b1; bus_rdata = rd; bus_byte_n = bn;
        @(posedge clk); @(negedge clk);
        bus_ack = 1'b0; bus_rdata = 16'h0; bus_byte_n = 1'b1;
    endtask

    task automatic expect_done(input string tag, input logic [15:0] exp_rd, input logic rd_chk);
        check({tag, " core_done"}, {31'd0, core_done}, 32'd1);
        check({tag, " bus_cyc closed"}, {31'd0, bus_cyc}, 32'd0);
        if (rd_chk) check({tag, " core_rdata"}, {16'd0, core_rdata}, {16'd0, exp_rd});
        @(negedge clk);
        check("R10 done pulse ends, ready back", {30'd0, core_done, req_ready}, 32'd1);
    endtask

    task automatic t_reset();
        check("R1 reset state", {28'd0, req_ready, bus_cyc, core_done, 1'b0},
              {28'd0, 1'b1, 1'b0, 1'b0, 1'b0});
        check("R1 enables high", {30'd0, bus_hen_n, bus_len_n}, 32'd3);
    endtask

    task automatic t_word_read_wide();
        logic [23:0] a; logic [1:0] en; logic [15:0] wd; logic we;
        issue(1'b0, 1'b1, 24'h001230, 16'h0);
        check("R2 ready low while busy", {31'd0, req_ready}, 32'd0);
        xfer(2, 16'hBEEF, 1'b1, a, en, wd, we);
        check("R3 word address", {8'd0, a}, 32'h001230);
        check("R3 both enables", {30'd0, en}, 32'd0);
        check("R2 read direction", {31'd0, we}, 32'd0);
        expect_done("R5 R7 wide read", 16'hBEEF, 1'b1);
    endtask

    task automatic t_word_read_split();
        logic [23:0] a; logic [1:0] en; logic [15:0] wd; logic we;
        issue(1'b0, 1'b1, 24'h00ABC4, 16'h0);
        xfer(1, 16'h77A1, 1'b0, a, en, wd, we);
        check("R5 split starts second", {31'd0, bus_cyc}, 32'd1);
        xfer(0, 16'h99B2, 1'b0, a, en, wd, we);
        check("R6 second address", {8'd0, a}, 32'h00ABC5);
        check("R6 low enable only", {30'd0, en}, 32'd2);
        expect_done("R8 R6 split read", 16'hB2A1, 1'b1);
    endtask

    task automatic t_word_write_split();
        logic [23:0] a; logic [1:0] en; logic [15:0] wd; logic we;
        issue(1'b1, 1'b1, 24'h000010, 16'h5AC3);
        xfer(0, 16'h0, 1'b0, a, en, wd, we);
        check("R3 first write data lanes", {16'd0, wd}, 32'h5AC3);
        check("R3 write direction", {31'd0, we}, 32'd1);
        xfer(1, 16'h0, 1'b1, a, en, wd, we);
        check("R6 second write data", {16'd0, wd}, 32'h5A5A);
        check("R6 second addr bit0", {8'd0, a}, 32'h000011);
        expect_done("R6 split write", 16'h0, 1'b0);
    endtask

    task automatic t_odd_word_addr();
        logic [23:0] a; logic [1:0] en; logic [15:0] wd; logic we;
        issue(1'b0, 1'b1, 24'h000101, 16'h0);
        xfer(0, 16'h1234, 1'b1, a, en, wd, we);
        check("R3 odd word address aligned", {8'd0, a}, 32'h000100);
        expect_done("R7 odd word read", 16'h1234, 1'b1);
    endtask

    task automatic t_byte_read(input logic [23:0] ad, input logic bn, input logic [15:0] rd,
                               input logic [1:0] exp_en, input logic [15:0] exp_rd);
        logic [23:0] a; logic [1:0] en; logic [15:0] wd; logic we;
        issue(1'b0, 1'b0, ad, 16'h0);
        xfer(1, rd, bn, a, en, wd, we);
        check("R4 byte address", {8'd0, a}, {8'd0, ad});
        check("R4 byte lane enable", {30'd0, en}, {30'd0, exp_en});
        expect_done("R9 R4 byte read", exp_rd, 1'b1);
    endtask

    task automatic t_byte_write_odd();
        logic [23:0] a; logic [1:0] en; logic [15:0] wd; logic we;
        issue(1'b1, 1'b0, 24'h000777, 16'hEE3C);
        xfer(0, 16'h0, 1'b0, a, en, wd, we);
        check("R4 byte write both lanes", {16'd0, wd}, 32'h3C3C);
        check("R4 high lane enable", {30'd0, en}, 32'd1);
        expect_done("R4 byte write single", 16'h0, 1'b0);
    endtask

    task automatic t_busy_ignore();
        logic [23:0] a; logic [1:0] en; logic [15:0] wd; logic we;
        issue(1'b0, 1'b0, 24'h000040, 16'h0);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 24'h000055; req_word = 1'b1;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        check("R2 busy request ignored addr", {8'd0, bus_addr}, 32'h000040);
        check("R2 busy request ignored dir", {31'd0, bus_we}, 32'd0);
        xfer(0, 16'h00C7, 1'b1, a, en, wd, we);
        expect_done("R2 busy read", 16'h00C7, 1'b1);
        @(negedge clk);
        check("R2 no stray transaction", {31'd0, bus_cyc}, 32'd0);
    endtask

    initial begin
        #200000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_word_read_wide();
        t_word_read_split();
        t_word_write_split();
        t_odd_word_addr();
        t_byte_read(24'h000200, 1'b1, 16'h11AA, 2'b10, 16'h00AA);
        t_byte_read(24'h000201, 1'b1, 16'h22BB, 2'b01, 16'h0022);
        t_byte_read(24'h000203, 1'b0, 16'h33CC, 2'b01, 16'h00CC);
        t_byte_write_odd();
        t_busy_ignore();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule